// File: doc/BRIEF.md
# Processor clock and standby controller

This block turns the system clock into the processor clock and runs the two low-power states of the processor, halt and stop. A 4-bit control word comes in over a small register port. Its two low bits pick the processor clock rate, and its two high bits ask for halt or for stop. The clock path has two stages: a pre-selector divides the system clock by 1, 2, 4 or 16, and a fixed divide-by-4 stage follows it. The processor clock period is therefore 4, 8, 16 or 64 system clocks. One processor clock period is one machine cycle.

Halt gates the processor clock off while the divider keeps counting for the peripherals. Stop also drops the oscillator-enable output, and the divider freezes. An interrupt release request ends halt at once. In stop, the same request only restarts the oscillator. The processor clock comes back after the interval timer reports that its wait has completed. Requests are acted on at processor clock boundaries, so the gated clock never shows a shortened phase.

Top module: `cpu_clk_standby`

## Requirements
- R1: The control word layout is [1:0] rate select, [2] halt request, [3] stop request. Rate select 0, 1, 2 and 3 give a processor clock period of 4, 8, 16 and 64 system clocks, made from a pre-selector of /1, /2, /4 and /16 followed by /4. The clock is high for the first half of each period.
- R2: Reset selects rate 3 (period 64). It clears both request bits, so the readback is 4'b0011. The processor clock starts high, the oscillator is enabled and the standby status reads 0 (running).
- R3: A new rate select takes effect only at the end of a full processor clock period. No period is shorter than 4 system clocks and no high phase is shorter than 2.
- R4: A halt request enters halt (status 1) at the next processor clock boundary. From then on the processor clock stays low and the oscillator stays enabled.
- R5: An interrupt release request in halt returns the status to 0 on the next system clock. The processor clock resumes at the next boundary with its selected period.
- R6: A stop request enters stop (status 2) at the next boundary. The oscillator enable goes low, the processor clock stays low and the divider holds its count.
- R7: In stop, the wait-complete pulse alone has no effect. An interrupt release request moves the block to oscillator restart (status 3) with the oscillator enabled and the processor clock still low. Only a wait-complete pulse in that state returns the status to 0.
- R8: Both request bits clear themselves when the standby state is entered, so the readback shows only the rate select afterwards.
- R9: If halt and stop are both requested, stop is entered.
- R10: Reset clears any standby state.
- R11: While the block is running, the interrupt release request and the wait-complete pulse are ignored: the status stays 0 and the processor clock period is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 4 | Control word to write |
| rd_data | output | 4 | Current control word |
| wake_req | input | 1 | Standby release request from interrupt control |
| wait_done | input | 1 | Wait-complete pulse from the interval timer |
| cpu_clk | output | 1 | Gated processor clock |
| osc_en | output | 1 | Oscillator enable |
| standby | output | 2 | 0 running, 1 halt, 2 stop, 3 oscillator restart |

## Verification
The properties assume that the processor does not write the control word while it is in a standby state, since its clock is off by then. They also assume that wake and wait-complete pulses come from their own sources and are not tied to the divider phase. The stimulus writes only while the status reads 0. It pulses the release inputs for one system clock in each state, including the states where they must be ignored. Processor clock periods are measured rise to rise. The measurement skips the rises around each rate change or resume, and those skipped rises are checked only against the shortest legal period and high phase.

// File: rtl/cks_pkg.sv
package cks_pkg;

    typedef enum logic [1:0] {
        PS_RUN  = 2'd0,
        PS_HALT = 2'd1,
        PS_STOP = 2'd2,
        PS_WAKE = 2'd3
    } pstate_t;

    localparam int SEL_W = 2;
    localparam int PRE_W = 4;

    // terminal count of the pre-selector: /1, /2, /4, /16
    function automatic logic [PRE_W-1:0] pre_limit(input logic [SEL_W-1:0] sel);
        logic [PRE_W-1:0] lim;
        case (sel)
            2'd0:    lim = 4'd0;
            2'd1:    lim = 4'd1;
            2'd2:    lim = 4'd3;
            default: lim = 4'd15;
        endcase
        return lim;
    endfunction

endpackage

// File: rtl/cks_ctl_reg.sv
module cks_ctl_reg
    import cks_pkg::*;
#(
    parameter logic [SEL_W-1:0] RST_SEL = 2'b11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [3:0]       wr_data,
    input  logic             clr_req,
    output logic [SEL_W-1:0] sel,
    output logic             halt_req,
    output logic             stop_req,
    output logic [3:0]       rd_data
);

    typedef struct packed {
        logic             stop;
        logic             halt;
        logic [SEL_W-1:0] sel;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (clr_req) begin
            ctl_d.halt = 1'b0;
            ctl_d.stop = 1'b0;
        end
        if (wr_en) begin
            ctl_d.sel  = wr_data[1:0];
            ctl_d.halt = wr_data[2];
            ctl_d.stop = wr_data[3];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{stop: 1'b0, halt: 1'b0, sel: RST_SEL};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sel      = ctl_q.sel;
    assign halt_req = ctl_q.halt;
    assign stop_req = ctl_q.stop;
    assign rd_data  = {ctl_q.stop, ctl_q.halt, ctl_q.sel};

endmodule

// File: rtl/cks_divider.sv
module cks_divider
    import cks_pkg::*;
#(
    parameter int               POST_DIV = 4,
    parameter logic [SEL_W-1:0] RST_SEL  = 2'b11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_en,
    input  logic [SEL_W-1:0] req_sel,
    output logic             boundary,
    output logic             phase_next
);

    localparam int             Q_W    = $clog2(POST_DIV);
    localparam logic [Q_W-1:0] Q_LAST = Q_W'(POST_DIV - 1);
    localparam logic [Q_W-1:0] Q_HALF = Q_W'(POST_DIV / 2);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [Q_W-1:0]   q;
        logic [SEL_W-1:0] act;
    } div_t;

    div_t div_d, div_q;
    logic pre_tick;

    always_comb begin
        div_d    = div_q;
        pre_tick = osc_en && (div_q.pre == pre_limit(div_q.act));
        boundary = pre_tick && (div_q.q == Q_LAST);
        if (osc_en) begin
            if (pre_tick) begin
                div_d.pre = '0;
                div_d.q   = (div_q.q == Q_LAST) ? '0 : div_q.q + 1'b1;
            end else begin
                div_d.pre = div_q.pre + 1'b1;
            end
        end
        if (boundary) begin
            div_d.act = req_sel;
        end
        phase_next = (div_d.q < Q_HALF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '{pre: '0, q: '0, act: RST_SEL};
        end else begin
            div_q <= div_d;
        end
    end

    // R3
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(div_q.act));

    // R6
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |=> ($stable(div_q.q) && $stable(div_q.pre)));

endmodule

// File: rtl/cks_power_fsm.sv
module cks_power_fsm
    import cks_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    boundary,
    input  logic    phase_next,
    input  logic    halt_req,
    input  logic    stop_req,
    input  logic    wake_req,
    input  logic    wait_done,
    output pstate_t state_o,
    output logic    clr_req,
    output logic    cpu_clk,
    output logic    osc_en
);

    typedef struct packed {
        pstate_t st;
        logic    gate;
        logic    clk_out;
    } fsm_t;

    fsm_t f_d, f_q;

    always_comb begin
        f_d     = f_q;
        clr_req = 1'b0;
        case (f_q.st)
            PS_RUN: begin
                if (boundary && stop_req) begin
                    f_d.st  = PS_STOP;
                    clr_req = 1'b1;
                end else if (boundary && halt_req) begin
                    f_d.st  = PS_HALT;
                    clr_req = 1'b1;
                end
            end
            PS_HALT: if (wake_req)  f_d.st = PS_RUN;
            PS_STOP: if (wake_req)  f_d.st = PS_WAKE;
            PS_WAKE: if (wait_done) f_d.st = PS_RUN;
            default: f_d.st = PS_RUN;
        endcase
        if (boundary) begin
            f_d.gate = (f_d.st == PS_RUN);
        end
        f_d.clk_out = f_d.gate && phase_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '{st: PS_RUN, gate: 1'b1, clk_out: 1'b1};
        end else begin
            f_q <= f_d;
        end
    end

    assign state_o = f_q.st;
    assign cpu_clk = f_q.clk_out;
    assign osc_en  = (f_q.st != PS_STOP);

    // R4
    gated_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st != PS_RUN) |-> !f_q.clk_out);

    // R5
    halt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == PS_HALT && wake_req) |=> (f_q.st == PS_RUN));

    // R7
    stop_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == PS_STOP) |=> (f_q.st == PS_STOP || f_q.st == PS_WAKE));

    // R7
    wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == PS_WAKE && !wait_done) |=> (f_q.st == PS_WAKE));

    // R9
    stop_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == PS_RUN && boundary && stop_req) |=> (f_q.st == PS_STOP));

endmodule

// File: rtl/cpu_clk_standby.sv
module cpu_clk_standby
    import cks_pkg::*;
#(
    parameter int               POST_DIV = 4,
    parameter logic [SEL_W-1:0] RST_SEL  = 2'b11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [3:0] wr_data,
    output logic [3:0] rd_data,
    input  logic       wake_req,
    input  logic       wait_done,
    output logic       cpu_clk,
    output logic       osc_en,
    output logic [1:0] standby
);

    logic [SEL_W-1:0] sel;
    logic             halt_req, stop_req, clr_req;
    logic             boundary, phase_next;
    pstate_t          state;

    cks_ctl_reg #(.RST_SEL(RST_SEL)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .clr_req  (clr_req),
        .sel      (sel),
        .halt_req (halt_req),
        .stop_req (stop_req),
        .rd_data  (rd_data)
    );

    cks_divider #(.POST_DIV(POST_DIV), .RST_SEL(RST_SEL)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .osc_en     (osc_en),
        .req_sel    (sel),
        .boundary   (boundary),
        .phase_next (phase_next)
    );

    cks_power_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .boundary   (boundary),
        .phase_next (phase_next),
        .halt_req   (halt_req),
        .stop_req   (stop_req),
        .wake_req   (wake_req),
        .wait_done  (wait_done),
        .state_o    (state),
        .clr_req    (clr_req),
        .cpu_clk    (cpu_clk),
        .osc_en     (osc_en)
    );

    assign standby = state;

    // R8
    req_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(standby != 2'd0) && !$past(wr_en)) |-> (rd_data[3:2] == 2'b00));

endmodule

// File: tb/tb_cpu_clk_standby.sv
`timescale 1ns/1ps
module tb_cpu_clk_standby;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_data = 4'd0;
    logic       wake_req = 1'b0;
    logic       wait_done = 1'b0;
    logic [3:0] rd_data;
    logic       cpu_clk;
    logic       osc_en;
    logic [1:0] standby;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    int exp_q[$];

    always #10 clk = ~clk;

    cpu_clk_standby dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .wake_req  (wake_req),
        .wait_done (wait_done),
        .cpu_clk   (cpu_clk),
        .osc_en    (osc_en),
        .standby   (standby)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // monitor: pops expected periods at every processor clock rise
    initial begin
        bit prev = 1'b0;
        int per = 0;
        int hi = 0;
        forever begin
            @(posedge clk);
            #5;
            if (!rst_n) begin
                prev = 1'b0; per = 0; hi = 0;
            end else begin
                if (cpu_clk && !prev) begin
                    if (exp_q.size() > 0) begin
                        int e;
                        e = exp_q.pop_front();
                        if (e == 0) begin
                            if (per != 0) begin
                                check(per >= 4, "R3 min period", per, 4);
                                check(hi >= 2, "R3 min high", hi, 2);
                            end
                        end else begin
                            check(per == e, "R1 period", per, e);
                            check(hi == e / 2, "R1 high phase", hi, e / 2);
                        end
                    end
                    per = 1; hi = 1;
                end else begin
                    per++;
                    if (cpu_clk) hi++;
                end
                prev = cpu_clk;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    task automatic push4(input int a, input int b, input int c, input int d);
        exp_q.push_back(a); exp_q.push_back(b);
        exp_q.push_back(c); exp_q.push_back(d);
    endtask

    task automatic drain(input string req);
        int n = 0;
        while (exp_q.size() > 0 && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    task automatic write_ctl(input logic [3:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_wake();
        @(negedge clk); wake_req = 1'b1;
        @(negedge clk); wake_req = 1'b0;
    endtask

    task automatic pulse_wait();
        @(negedge clk); wait_done = 1'b1;
        @(negedge clk); wait_done = 1'b0;
    endtask

    task automatic wait_state(input logic [1:0] s);
        for (int i = 0; i < 200; i++) begin
            if (standby == s) break;
            @(negedge clk);
        end
    endtask

    task automatic count_high(input int cycles, output int highs);
        highs = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (cpu_clk) highs++;
        end
    endtask

    initial begin
        int h;
        repeat (3) @(negedge clk);
        // R2: reset state
        check(rd_data == 4'b0011, "R2 readback", rd_data, 3);
        check(cpu_clk == 1'b1, "R2 cpu_clk", cpu_clk, 1);
        check(osc_en == 1'b1, "R2 osc_en", osc_en, 1);
        check(standby == 2'd0, "R2 standby", standby, 0);
        push4(0, 0, 64, 64);
        rst_n = 1'b1;
        drain("R2 slowest rate");

        // R1 / R3: rate changes at boundaries
        push4(0, 0, 16, 16); write_ctl(4'b0010); drain("R1 rate 2");
        push4(0, 0, 8, 8);   write_ctl(4'b0001); drain("R1 rate 1");
        push4(0, 0, 4, 4);   write_ctl(4'b0000); drain("R1 rate 0");

        // R11: release inputs ignored while running
        push4(4, 4, 4, 4);
        pulse_wake();
        check(standby == 2'd0, "R11 wake in run", standby, 0);
        pulse_wait();
        check(standby == 2'd0, "R11 wait in run", standby, 0);
        drain("R11 period kept");

        // R4 / R8: halt
        write_ctl(4'b0100);
        wait_state(2'd1);
        check(standby == 2'd1, "R4 halt entered", standby, 1);
        check(osc_en == 1'b1, "R4 osc on in halt", osc_en, 1);
        check(cpu_clk == 1'b0, "R4 clock low", cpu_clk, 0);
        check(rd_data == 4'b0000, "R8 halt bit cleared", rd_data, 0);
        count_high(30, h);
        check(h == 0, "R4 clock held low", h, 0);

        // R5: release from halt
        exp_q.push_back(0); exp_q.push_back(4); exp_q.push_back(4);
        pulse_wake();
        check(standby == 2'd0, "R5 halt released", standby, 0);
        drain("R5 clock resumed");

        // R6 / R7 / R8: stop
        write_ctl(4'b1000);
        wait_state(2'd2);
        check(standby == 2'd2, "R6 stop entered", standby, 2);
        check(osc_en == 1'b0, "R6 osc off", osc_en, 0);
        check(cpu_clk == 1'b0, "R6 clock low", cpu_clk, 0);
        check(rd_data == 4'b0000, "R8 stop bit cleared", rd_data, 0);
        pulse_wait();
        check(standby == 2'd2, "R7 wait alone ignored", standby, 2);
        count_high(10, h);
        check(h == 0, "R6 clock held in stop", h, 0);
        pulse_wake();
        check(standby == 2'd3, "R7 restart state", standby, 3);
        check(osc_en == 1'b1, "R7 osc restarted", osc_en, 1);
        count_high(12, h);
        check(h == 0, "R7 clock low while waiting", h, 0);
        exp_q.push_back(0); exp_q.push_back(4); exp_q.push_back(4);
        pulse_wait();
        check(standby == 2'd0, "R7 wait completes", standby, 0);
        drain("R7 clock resumed");

        // R9: both requests -> stop
        write_ctl(4'b1100);
        wait_state(2'd2);
        check(standby == 2'd2, "R9 stop wins", standby, 2);
        check(rd_data == 4'b0000, "R8 both bits cleared", rd_data, 0);
        pulse_wake();
        exp_q.push_back(0); exp_q.push_back(4);
        pulse_wait();
        check(standby == 2'd0, "R9 back to run", standby, 0);
        drain("R9 clock resumed");

        // R10: reset inside halt
        write_ctl(4'b0100);
        wait_state(2'd1);
        check(standby == 2'd1, "R10 halt before reset", standby, 1);
        @(negedge clk); rst_n = 1'b0;
        #1;
        check(standby == 2'd0, "R10 standby cleared", standby, 0);
        check(rd_data == 4'b0011, "R10 readback reset", rd_data, 3);
        @(negedge clk);
        push4(0, 0, 64, 64);
        rst_n = 1'b1;
        drain("R10 slowest rate after reset");

        finish_run();
    end

endmodule